// File: doc/BRIEF.md
# Output Pin Tone and Level Controller

This block turns two control bits into the logic levels of two output pins, called here the primary pin (R00) and the secondary pin (R01). Each pin is given a function when the block is built. The secondary pin can be a plain level output or a tone output. The primary pin can be a plain level output, an inverted tone output gated by its own bit, an inverted tone output gated by the secondary bit, or a clock output. The tone clock and the output clock come from elsewhere and arrive as slow waveforms sampled by the block clock.

A clocked output is gated so that an enable or disable only takes effect while its waveform sits at its low level. A pulse on a pin therefore always spans a whole high phase of its source and is never shortened or started late. Any clocked pin that is switched off rests low. When the primary pin carries the inverted tone, it is in antiphase with the tone on the secondary pin.

Top module: `buzzer_pin_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until a bit is written, both control bits are 0 and both pins are low.
- R2: `ctl_wr_data[0]` is the primary control bit and `ctl_wr_data[1]` is the secondary control bit. Each bit is stored on a clock edge only when the matching bit of `ctl_wr_en` is 1; otherwise it holds its value.
- R3: In level mode, a pin equals its own control bit, and it follows that bit one clock after the bit changes.
- R4: In tone mode, the secondary pin outputs the tone clock, delayed by one clock, while its gate is open. The gate takes the secondary bit. With the bit at 0, the pin settles low.
- R5: In self-gated inverted-tone mode, the primary pin outputs the inverse of the tone clock, delayed by one clock, while a gate fed by the primary bit is open. Otherwise it is low.
- R6: In peer-gated inverted-tone mode, the primary pin outputs the inverted tone under a gate fed by the secondary bit. The primary bit has no effect on the pin.
- R7: In either inverted-tone mode, with the secondary pin in tone mode, the two pins are never high in the same cycle.
- R8: In clock-output mode, the primary pin outputs the output clock, delayed by one clock, while a gate fed by the primary bit is open. Otherwise it is low.
- R9: A gate samples its enable only on edges where its source waveform (the inverted tone, for the inverted modes) is low. A pin rises only one clock after its source rises and falls only one clock after its source falls. While the source stays high, a high pin stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 2 | Per-bit write enables for the control bits |
| ctl_wr_data | input | 2 | Write data; bit 0 is primary, bit 1 is secondary |
| tone_clk_i | input | 1 | Tone waveform, sampled by clk |
| fclk_i | input | 1 | Output-clock waveform, sampled by clk |
| pin_pri_o | output | 1 | Primary pin level (R00) |
| pin_sec_o | output | 1 | Secondary pin level (R01) |

## Verification
A control-bit write and an edge of a gated source waveform can arrive in the same cycle. In that case the write has to wait for the next low sample of the source, and any pulse already under way has to run to its end. The bench provokes this by writing the secondary bit while the tone is held high, both to enable and to disable. It also does so through random writes placed over randomly timed tone and output-clock edges on four builds of the block. Each pin is judged every cycle against a cycle model of the requirements, and the antiphase and no-runt rules are watched as properties.

// File: rtl/bpc_pkg.sv
// Shared types and constants for the output pin tone/level controller.
// Assumes: exactly two control bits, one per pin.
package bpc_pkg;
    localparam int BPC_NBITS = 2;
    localparam int BPC_IDX_PRI = 0;
    localparam int BPC_IDX_SEC = 1;

    // Build-time function of the primary pin
    typedef enum logic [1:0] {
        PRI_LEVEL      = 2'd0,
        PRI_TONE_N_OWN = 2'd1,
        PRI_TONE_N_SEC = 2'd2,
        PRI_CLKOUT     = 2'd3
    } pri_mode_e;

    // Build-time function of the secondary pin
    typedef enum logic {
        SEC_LEVEL = 1'b0,
        SEC_TONE  = 1'b1
    } sec_mode_e;
endpackage

// File: rtl/bpc_ctl_bits.sv
// Control bit storage with per-bit write enables.
// Assumes: writes are synchronous to clk; reset clears every bit.
module bpc_ctl_bits #(
    parameter int NBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] wr_en,
    input  logic [NBITS-1:0] wr_data,
    output logic [NBITS-1:0] q
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        // Store one bit when its enable is set
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (wr_en[i])
                q[i] <= wr_data[i];
        end
    end
endmodule

// File: rtl/bpc_clk_gate.sv
// Runt-free gate for a sampled waveform, with a registered pin output.
// The gate takes the enable only on edges where the waveform is low, so a
// high phase on the pin always spans a whole high phase of the source.
// Assumes: wave is already synchronous to clk.
module bpc_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic wave,
    output logic pin
);
    logic gate_q;

    // Update the gate only while the source sits low
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else if (!wave)
            gate_q <= en;
    end

    // Register the gated waveform onto the pin
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin <= 1'b0;
        else
            pin <= gate_q & wave;
    end
endmodule

// File: rtl/bpc_level_out.sv
// Plain level output: the pin repeats a control bit one clock later.
// Assumes: bit is a registered control bit.
module bpc_level_out (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic pin
);
    // Copy the control bit onto the pin
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin <= 1'b0;
        else
            pin <= bit_i;
    end
endmodule

// File: rtl/buzzer_pin_ctrl.sv
// Top: two output pins driven from two control bits, a tone clock and an
// output clock, with the pin functions chosen by parameters.
// Assumes: tone_clk_i and fclk_i are slow and synchronous to clk.
module buzzer_pin_ctrl
    import bpc_pkg::*;
#(
    parameter pri_mode_e PRI_MODE = PRI_CLKOUT,
    parameter sec_mode_e SEC_MODE = SEC_TONE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ctl_wr_en,
    input  logic [1:0] ctl_wr_data,
    input  logic       tone_clk_i,
    input  logic       fclk_i,
    output logic       pin_pri_o,
    output logic       pin_sec_o
);
    localparam int NB = BPC_NBITS;

    logic [NB-1:0] ctl_q;

    bpc_ctl_bits #(.NBITS(NB)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .q       (ctl_q)
    );

    // Secondary pin: level or tone
    if (SEC_MODE == SEC_TONE) begin : g_sec_tone
        bpc_clk_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ctl_q[BPC_IDX_SEC]),
            .wave  (tone_clk_i),
            .pin   (pin_sec_o)
        );
    end else begin : g_sec_level
        bpc_level_out u_lvl (
            .clk   (clk),
            .rst_n (rst_n),
            .bit_i (ctl_q[BPC_IDX_SEC]),
            .pin   (pin_sec_o)
        );
    end

    // Primary pin: level, inverted tone (own or peer gate), or clock output
    if (PRI_MODE == PRI_LEVEL) begin : g_pri_level
        bpc_level_out u_lvl (
            .clk   (clk),
            .rst_n (rst_n),
            .bit_i (ctl_q[BPC_IDX_PRI]),
            .pin   (pin_pri_o)
        );
    end else begin : g_pri_gated
        logic pri_en;
        logic pri_wave;
        if (PRI_MODE == PRI_CLKOUT) begin : g_src_fclk
            assign pri_wave = fclk_i;
            assign pri_en   = ctl_q[BPC_IDX_PRI];
        end else if (PRI_MODE == PRI_TONE_N_SEC) begin : g_src_peer
            assign pri_wave = ~tone_clk_i;
            assign pri_en   = ctl_q[BPC_IDX_SEC];
        end else begin : g_src_own
            assign pri_wave = ~tone_clk_i;
            assign pri_en   = ctl_q[BPC_IDX_PRI];
        end
        bpc_clk_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (pri_en),
            .wave  (pri_wave),
            .pin   (pin_pri_o)
        );
    end
endmodule

// File: rtl/bpc_checker.sv
// Property checker for buzzer_pin_ctrl, attached with bind.
// Assumes: the control bit vector of the top is reachable as ctl_q.
module bpc_checker
    import bpc_pkg::*;
#(
    parameter pri_mode_e PRI_MODE = PRI_CLKOUT,
    parameter sec_mode_e SEC_MODE = SEC_TONE
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ctl_q,
    input logic       tone_clk_i,
    input logic       fclk_i,
    input logic       pin_pri_o,
    input logic       pin_sec_o
);
    logic pri_src;
    logic pri_en;
    assign pri_src = (PRI_MODE == PRI_CLKOUT) ? fclk_i : ~tone_clk_i;
    assign pri_en  = (PRI_MODE == PRI_TONE_N_SEC) ? ctl_q[1] : ctl_q[0];

    AST_RESET_PINS_LOW: assert property (@(posedge clk)
        !rst_n |=> (!pin_pri_o && !pin_sec_o)); // R1

    if (SEC_MODE == SEC_TONE) begin : g_sec_tone
        AST_SEC_RISE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pin_sec_o) |-> ($past(tone_clk_i) && !$past(tone_clk_i, 2))); // R9
        AST_SEC_NO_TRUNCATE: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_sec_o && tone_clk_i) |=> pin_sec_o); // R9
        AST_SEC_FALL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pin_sec_o) |-> !$past(tone_clk_i)); // R9
        AST_SEC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pin_sec_o) |-> $past(ctl_q[1], 2)); // R4
    end else begin : g_sec_level
        AST_SEC_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            pin_sec_o == $past(ctl_q[1])); // R3
    end

    if (PRI_MODE == PRI_LEVEL) begin : g_pri_level
        AST_PRI_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            pin_pri_o == $past(ctl_q[0])); // R3
    end else begin : g_pri_gated
        AST_PRI_RISE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pin_pri_o) |-> ($past(pri_src) && !$past(pri_src, 2))); // R9
        AST_PRI_NO_TRUNCATE: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_pri_o && pri_src) |=> pin_pri_o); // R9
        AST_PRI_FALL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pin_pri_o) |-> !$past(pri_src)); // R9
        AST_PRI_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pin_pri_o) |-> $past(pri_en, 2)); // R8
    end

    if (SEC_MODE == SEC_TONE &&
        (PRI_MODE == PRI_TONE_N_OWN || PRI_MODE == PRI_TONE_N_SEC)) begin : g_anti
        AST_PINS_ANTIPHASE: assert property (@(posedge clk) disable iff (!rst_n)
            !(pin_pri_o && pin_sec_o)); // R7
    end
endmodule

bind buzzer_pin_ctrl bpc_checker #(
    .PRI_MODE (PRI_MODE),
    .SEC_MODE (SEC_MODE)
) u_bpc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_q      (ctl_q),
    .tone_clk_i (tone_clk_i),
    .fclk_i     (fclk_i),
    .pin_pri_o  (pin_pri_o),
    .pin_sec_o  (pin_sec_o)
);

// File: tb/buzzer_pin_ctrl_bench.sv
// Bench: four builds of the controller share one stimulus. Each pin is
// compared every cycle with a cycle model computed from the requirements.
module buzzer_pin_ctrl_bench;
    import bpc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wr_en = 2'b00;
    logic [1:0] wr_data = 2'b00;
    logic       tone = 1'b0;
    logic       fclk = 1'b0;
    logic [3:0] p_pri;
    logic [3:0] p_sec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Instance 0: clock output / tone. 1: level / level.
    // Instance 2: own-gated inverted tone / tone. 3: peer-gated inverted tone / tone.
    buzzer_pin_ctrl u_buzzer_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(wr_en), .ctl_wr_data(wr_data),
        .tone_clk_i(tone), .fclk_i(fclk), .pin_pri_o(p_pri[0]), .pin_sec_o(p_sec[0]));
    buzzer_pin_ctrl #(.PRI_MODE(PRI_LEVEL), .SEC_MODE(SEC_LEVEL)) u_lvl (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(wr_en), .ctl_wr_data(wr_data),
        .tone_clk_i(tone), .fclk_i(fclk), .pin_pri_o(p_pri[1]), .pin_sec_o(p_sec[1]));
    buzzer_pin_ctrl #(.PRI_MODE(PRI_TONE_N_OWN), .SEC_MODE(SEC_TONE)) u_own (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(wr_en), .ctl_wr_data(wr_data),
        .tone_clk_i(tone), .fclk_i(fclk), .pin_pri_o(p_pri[2]), .pin_sec_o(p_sec[2]));
    buzzer_pin_ctrl #(.PRI_MODE(PRI_TONE_N_SEC), .SEC_MODE(SEC_TONE)) u_peer (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(wr_en), .ctl_wr_data(wr_data),
        .tone_clk_i(tone), .fclk_i(fclk), .pin_pri_o(p_pri[2+1]), .pin_sec_o(p_sec[2+1]));

    // Cycle model state
    logic [1:0] m_bits;
    logic [3:0] m_gpri, m_gsec, m_ppri, m_psec;

    function automatic string pri_tag(int i);
        case (i)
            0: return "R8";
            1: return "R3";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic string sec_tag(int i);
        return (i == 1) ? "R3" : "R4";
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Advance the model by one edge with the inputs that were applied
    task automatic model_step();
        logic [1:0] nb;
        logic wv, en;
        if (!rst_n) begin
            m_bits = 2'b00; m_gpri = '0; m_gsec = '0; m_ppri = '0; m_psec = '0;
            return;
        end
        nb = (m_bits & ~wr_en) | (wr_data & wr_en);
        for (int i = 0; i < 4; i++) begin
            if (i == 1) begin
                m_psec[i] = m_bits[1];
                m_ppri[i] = m_bits[0];
            end else begin
                m_psec[i] = m_gsec[i] & tone;
                if (!tone) m_gsec[i] = m_bits[1];
                wv = (i == 0) ? fclk : ~tone;
                en = (i == 3) ? m_bits[1] : m_bits[0];
                m_ppri[i] = m_gpri[i] & wv;
                if (!wv) m_gpri[i] = en;
            end
        end
        m_bits = nb;
    endtask

    task automatic compare_all();
        for (int i = 0; i < 4; i++) begin
            check(pri_tag(i), p_pri[i], m_ppri[i], $sformatf("primary pin inst%0d", i));
            check(sec_tag(i), p_sec[i], m_psec[i], $sformatf("secondary pin inst%0d", i));
        end
        check("R7", p_pri[2] & p_sec[2], 1'b0, "own-gated pins both high");
        check("R7", p_pri[3] & p_sec[3], 1'b0, "peer-gated pins both high");
    endtask

    // One clock: drive at negedge, model and compare at the next negedge
    task automatic cyc(logic [1:0] we, logic [1:0] wd, logic tn, logic fc);
        wr_en = we; wr_data = wd; tone = tn; fclk = fc;
        @(posedge clk);
        @(negedge clk);
        model_step();
        compare_all();
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int tone_cnt, fclk_cnt;
        void'($urandom(32'd20240611));
        m_bits = 2'b00; m_gpri = '0; m_gsec = '0; m_ppri = '0; m_psec = '0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) cyc(2'b11, 2'b11, 1'b1, 1'b1);
        // R1: reset holds both pins low even with writes and clocks active
        for (int i = 0; i < 4; i++) begin
            check("R1", p_pri[i], 1'b0, "primary low in reset");
            check("R1", p_sec[i], 1'b0, "secondary low in reset");
        end
        rst_n = 1'b1;
        cyc(2'b00, 2'b00, 1'b0, 1'b0);
        check("R1", p_sec[1] | p_pri[1], 1'b0, "level pins low after reset");

        // R9: enable the secondary tone while the tone is held high
        cyc(2'b10, 2'b11, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) cyc(2'b00, 2'b00, 1'b1, 1'b0);
        check("R9", p_sec[0], 1'b0, "no late start while tone high");
        // R2: only the enabled bit was written
        check("R2", p_sec[1], 1'b1, "secondary bit written");
        check("R2", p_pri[1], 1'b0, "primary bit untouched");
        cyc(2'b00, 2'b00, 1'b0, 1'b0);
        cyc(2'b00, 2'b00, 1'b1, 1'b0);
        check("R4", p_sec[0], 1'b1, "tone passes after low sample");
        // R9: disable during a high phase, pulse must run to its end
        cyc(2'b10, 2'b00, 1'b1, 1'b0);
        cyc(2'b00, 2'b00, 1'b1, 1'b0);
        cyc(2'b00, 2'b00, 1'b1, 1'b0);
        check("R9", p_sec[0], 1'b1, "pulse not truncated by disable");
        cyc(2'b00, 2'b00, 1'b0, 1'b0);
        cyc(2'b00, 2'b00, 1'b1, 1'b0);
        check("R4", p_sec[0], 1'b0, "disabled tone rests low");

        // R6: primary bit alone has no effect in peer-gated mode
        cyc(2'b11, 2'b01, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            cyc(2'b00, 2'b00, k[0], 1'b0);
            check("R6", p_pri[3], 1'b0, "peer pin ignores primary bit");
        end

        // Random phase: random tone/fclk half-periods and sparse writes
        tone_cnt = 1; fclk_cnt = 1;
        for (int n = 0; n < 6000; n++) begin
            logic [1:0] we, wd;
            logic tn, fc;
            tn = tone; fc = fclk;
            tone_cnt--; fclk_cnt--;
            if (tone_cnt == 0) begin tn = ~tn; tone_cnt = 1 + int'($urandom_range(4)); end
            if (fclk_cnt == 0) begin fc = ~fc; fclk_cnt = 1 + int'($urandom_range(3)); end
            we = ($urandom_range(7) == 0) ? 2'($urandom_range(3)) : 2'b00;
            wd = 2'($urandom_range(3));
            cyc(we, wd, tn, fc);
        end
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run is counted as a failed check
    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule